// File: doc/BRIEF.md
# Interrupt Cause Group Register Bank

This block gathers up to 32 interrupt sources into one group and puts that group behind a word-addressed APB slave. Each source first passes through a two-flop synchroniser. It is then captured into a cause bit. Each bit can be captured on the source level or on its rising edge, chosen per bit. A group-wide control bit can override the per-bit choice.

Software can inject causes, clear them and mask them. The clear and mask-clear registers act on zero bits, not on one bits. An acknowledge input, one bit per source, can clear cause bits and re-mask sources automatically.

The block drives five outputs. One is a summary interrupt. The other four are severity lines: error, abort, fatal and log. Each output is the OR of the cause bits that its own mask leaves open.

Top module: `irq_group_bank`

## Requirements
- R1: Registers sit at these byte offsets:
  - 0x00: cause
  - 0x08: cause-set
  - 0x10: mask
  - 0x18: mask-clear
  - 0x20: status
  - 0x28: control
  - 0x2C, 0x30, 0x34, 0x38: error, abort, fatal and log masks
  - 0x3C: edge-select

  After reset, the mask and all four severity masks read 0xFFFFFFFF. Cause, status and edge-select read 0, and every output is low.
- R2: Writing to cause clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R3: Writing to cause-set sets each cause bit written as 1. A 0 has no effect. Cause-set always reads 0.
- R4: Mask is read/write. Writing to mask-clear clears each mask bit written as 0 and leaves bits written as 1 alone. Mask-clear reads 0.
- R5: In level mode, a cause bit is set on every clock in which its synchronised source is 1. A source change reaches cause, and the status register, three clock edges after it is applied.
- R6: In edge mode, a cause bit is set only when the synchronised source is 1 and the latched status bit is 0. Status holds the synchronised source from the previous clock. An edge-select bit of 1 selects edge mode for that source.
- R7: When control bit 6 is 1, control bit 3 selects the mode for all bits: 1 means edge, 0 means level. The edge-select register is then ignored.
- R8: When control bit 0 is 1, a read of cause returns the current value and then clears every cause bit.
- R9: When control bit 2 is 1, an acknowledge bit clears its cause bit. When control bit 1 is 1, an acknowledge bit sets its mask bit. An acknowledge has priority over a mask or mask-clear write in the same cycle.
- R10: A hardware set of a bit wins over a software clear of the same bit in the same cycle.
- R11: irq_summary is the OR of (cause AND NOT mask). Each severity output is the OR of (cause AND NOT its own severity mask).
- R12: Control bits 29:28 read as 1. Only control bits 0, 1, 2, 3 and 6 are stored, and all other control bits read 0. An offset outside 0x00–0x3F, or one not listed in R1, reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid in the access phase |
| src_in | input | NSRC | Raw interrupt sources, asynchronous |
| irq_ack | input | NSRC | Per-source acknowledge pulses |
| irq_summary | output | 1 | OR of unmasked causes |
| sev_error | output | 1 | Error severity line |
| sev_abort | output | 1 | Abort severity line |
| sev_fatal | output | 1 | Fatal severity line |
| sev_log | output | 1 | Log severity line |

## Verification
The assertions assume the following about the inputs:
- Every APB access phase follows a setup phase.
- No read and write are issued together.
- paddr and pwdata stay stable for the whole transfer.
- irq_ack is a clean single-cycle pulse that is never X after reset.

The stimulus drives every input on the falling clock edge and issues one transfer at a time. Acknowledge is raised for exactly one cycle. Sources change only between transfers, so each transfer sees a settled synchroniser pipeline relative to its own clock edge.

// File: rtl/irq_grp_pkg.sv
package irq_grp_pkg;

   localparam int NSEV = 4;

   typedef enum int unsigned {
      SEV_ERROR = 0,
      SEV_ABORT = 1,
      SEV_FATAL = 2,
      SEV_LOG   = 3
   } sev_e;

   // byte offsets inside one group window
   localparam logic [5:0] OFF_CAUSE    = 6'h00;
   localparam logic [5:0] OFF_SET      = 6'h08;
   localparam logic [5:0] OFF_MASK     = 6'h10;
   localparam logic [5:0] OFF_MCLR     = 6'h18;
   localparam logic [5:0] OFF_STATUS   = 6'h20;
   localparam logic [5:0] OFF_CTRL     = 6'h28;
   localparam logic [5:0] OFF_SEV_BASE = 6'h2C;
   localparam logic [5:0] OFF_EDGE     = 6'h3C;

   // control word bit positions
   localparam int CB_CLR_RD   = 0;
   localparam int CB_ACK_MSK  = 1;
   localparam int CB_ACK_CLR  = 2;
   localparam int CB_GRP_EDGE = 3;
   localparam int CB_GRP_OVR  = 6;
   localparam int CB_REV_LO   = 28;
   localparam logic [1:0] REV_VAL = 2'd1;

   typedef struct packed {
      logic grp_ovr;
      logic grp_edge;
      logic ack_clr;
      logic ack_msk;
      logic clr_rd;
   } ctrl_t;

endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync #(
   parameter int NSRC   = 32,
   parameter int STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_async,
   output logic [NSRC-1:0] src_sync
);

   if (STAGES < 2) begin : g_bad_stages
      $error("irq_src_sync: STAGES must be at least 2");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [NSRC-1:0] q;
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= src_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= g_stage[s-1].q;
         end
      end
   end

   assign src_sync = g_stage[STAGES-1].q;

endmodule

// File: rtl/irq_sev_or.sv
module irq_sev_or #(
   parameter int NSRC = 32
) (
   input  logic [NSRC-1:0] cause,
   input  logic [NSRC-1:0] line_mask,
   output logic            line_out
);

   assign line_out = |(cause & ~line_mask);

endmodule

// File: rtl/irq_cause_core.sv
module irq_cause_core
   import irq_grp_pkg::*;
#(
   parameter int NSRC = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_sync,
   input  logic [NSRC-1:0] edge_sel,
   input  ctrl_t           ctrl,
   input  logic            cause_wr,
   input  logic            set_wr,
   input  logic            mask_wr,
   input  logic            mclr_wr,
   input  logic            cause_rd,
   input  logic [NSRC-1:0] wdata,
   input  logic [NSRC-1:0] irq_ack,
   output logic [NSRC-1:0] cause_q,
   output logic [NSRC-1:0] mask_q,
   output logic [NSRC-1:0] status_q
);

   logic [NSRC-1:0] edge_mode;
   logic [NSRC-1:0] hw_set;
   logic [NSRC-1:0] cause_d;
   logic [NSRC-1:0] mask_d;

   // group override replaces the per-bit choice
   always_comb begin
      edge_mode = ctrl.grp_ovr ? {NSRC{ctrl.grp_edge}} : edge_sel;
      hw_set    = src_sync & ~(edge_mode & status_q);
   end

   // software clears first, hardware and software sets last
   always_comb begin
      cause_d = cause_q;
      if (cause_rd && ctrl.clr_rd) cause_d = '0;
      if (cause_wr)                cause_d = cause_d & wdata;
      if (ctrl.ack_clr)            cause_d = cause_d & ~irq_ack;
      if (set_wr)                  cause_d = cause_d | wdata;
      cause_d = cause_d | hw_set;
   end

   always_comb begin
      mask_d = mask_q;
      if (mask_wr)      mask_d = wdata;
      if (mclr_wr)      mask_d = mask_d & wdata;
      if (ctrl.ack_msk) mask_d = mask_d | irq_ack;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause_q  <= '0;
         mask_q   <= '1;
         status_q <= '0;
      end else begin
         cause_q  <= cause_d;
         mask_q   <= mask_d;
         status_q <= src_sync;
      end
   end

   // R10
   hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|hw_set) |=> ((cause_q & $past(hw_set)) == $past(hw_set)));

   // R9
   ack_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.ack_msk && (|irq_ack)) |=> ((mask_q & $past(irq_ack)) == $past(irq_ack)));

   // R8
   clr_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_rd && ctrl.clr_rd && !(|hw_set)) |=> (cause_q == '0));

   // R6
   edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.grp_ovr && ctrl.grp_edge && cause_wr && !set_wr && !ctrl.clr_rd
       && (wdata == '0) && (src_sync == status_q)) |=> (cause_q == '0));

endmodule

// File: rtl/irq_group_bank.sv
module irq_group_bank
   import irq_grp_pkg::*;
#(
   parameter int NSRC        = 32,
   parameter int ADDR_W      = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [31:0]       pwdata,
   output logic [31:0]       prdata,
   input  logic [NSRC-1:0]   src_in,
   input  logic [NSRC-1:0]   irq_ack,
   output logic              irq_summary,
   output logic              sev_error,
   output logic              sev_abort,
   output logic              sev_fatal,
   output logic              sev_log
);

   localparam int DW = 32;

   if (NSRC < 1 || NSRC > DW) begin : g_bad_nsrc
      $error("irq_group_bank: NSRC must be within 1..32");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("irq_group_bank: ADDR_W must cover the 64-byte group window");
   end

   // ---------------- address decode ----------------
   logic            wr_acc, rd_acc, in_grp;
   logic [5:0]      off;
   logic [NSRC-1:0] wdata;

   assign wr_acc = psel && penable && pwrite;
   assign rd_acc = psel && penable && !pwrite;
   assign off    = {paddr[5:2], 2'b00};
   assign wdata  = pwdata[NSRC-1:0];

   if (ADDR_W > 6) begin : g_hi_dec
      assign in_grp = ~|paddr[ADDR_W-1:6];
   end else begin : g_no_hi
      assign in_grp = 1'b1;
   end

   logic hit_cause, hit_set, hit_mask, hit_mclr, hit_status, hit_ctrl, hit_edge;
   assign hit_cause  = in_grp && (off == OFF_CAUSE);
   assign hit_set    = in_grp && (off == OFF_SET);
   assign hit_mask   = in_grp && (off == OFF_MASK);
   assign hit_mclr   = in_grp && (off == OFF_MCLR);
   assign hit_status = in_grp && (off == OFF_STATUS);
   assign hit_ctrl   = in_grp && (off == OFF_CTRL);
   assign hit_edge   = in_grp && (off == OFF_EDGE);

   // ---------------- control and edge-select ----------------
   ctrl_t           ctrl_q;
   logic [NSRC-1:0] edge_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         edge_q <= '0;
      end else begin
         if (wr_acc && hit_ctrl) begin
            ctrl_q.clr_rd   <= pwdata[CB_CLR_RD];
            ctrl_q.ack_msk  <= pwdata[CB_ACK_MSK];
            ctrl_q.ack_clr  <= pwdata[CB_ACK_CLR];
            ctrl_q.grp_edge <= pwdata[CB_GRP_EDGE];
            ctrl_q.grp_ovr  <= pwdata[CB_GRP_OVR];
         end
         if (wr_acc && hit_edge) edge_q <= wdata;
      end
   end

   // ---------------- synchroniser and cause core ----------------
   logic [NSRC-1:0] src_sync, cause_q, mask_q, status_q;

   irq_src_sync #(.NSRC(NSRC), .STAGES(SYNC_STAGES)) i_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_async (src_in),
      .src_sync  (src_sync)
   );

   irq_cause_core #(.NSRC(NSRC)) i_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_sync (src_sync),
      .edge_sel (edge_q),
      .ctrl     (ctrl_q),
      .cause_wr (wr_acc && hit_cause),
      .set_wr   (wr_acc && hit_set),
      .mask_wr  (wr_acc && hit_mask),
      .mclr_wr  (wr_acc && hit_mclr),
      .cause_rd (rd_acc && hit_cause),
      .wdata    (wdata),
      .irq_ack  (irq_ack),
      .cause_q  (cause_q),
      .mask_q   (mask_q),
      .status_q (status_q)
   );

   // ---------------- severity masks and lines ----------------
   logic [NSEV-1:0] sev_line;
   logic [NSEV-1:0] sev_hit;
   logic [DW-1:0]   sev_rword [NSEV];

   for (genvar i = 0; i < NSEV; i++) begin : g_sev
      localparam logic [5:0] OFF_I = OFF_SEV_BASE + 6'(4 * i);
      logic [NSRC-1:0] mask_r;

      assign sev_hit[i] = in_grp && (off == OFF_I);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    mask_r <= '1;
         else if (wr_acc && sev_hit[i]) mask_r <= wdata;
      end

      assign sev_rword[i] = DW'(mask_r);

      irq_sev_or #(.NSRC(NSRC)) i_line (
         .cause     (cause_q),
         .line_mask (mask_r),
         .line_out  (sev_line[i])
      );
   end

   irq_sev_or #(.NSRC(NSRC)) i_summary (
      .cause     (cause_q),
      .line_mask (mask_q),
      .line_out  (irq_summary)
   );

   assign sev_error = sev_line[SEV_ERROR];
   assign sev_abort = sev_line[SEV_ABORT];
   assign sev_fatal = sev_line[SEV_FATAL];
   assign sev_log   = sev_line[SEV_LOG];

   // ---------------- read mux ----------------
   logic [DW-1:0] ctrl_word;
   logic [DW-1:0] rdata;

   always_comb begin
      ctrl_word                       = '0;
      ctrl_word[CB_CLR_RD]            = ctrl_q.clr_rd;
      ctrl_word[CB_ACK_MSK]           = ctrl_q.ack_msk;
      ctrl_word[CB_ACK_CLR]           = ctrl_q.ack_clr;
      ctrl_word[CB_GRP_EDGE]          = ctrl_q.grp_edge;
      ctrl_word[CB_GRP_OVR]           = ctrl_q.grp_ovr;
      ctrl_word[CB_REV_LO+1:CB_REV_LO] = REV_VAL;
   end

   always_comb begin
      rdata = '0;
      if (hit_cause)  rdata = DW'(cause_q);
      if (hit_mask)   rdata = DW'(mask_q);
      if (hit_status) rdata = DW'(status_q);
      if (hit_ctrl)   rdata = ctrl_word;
      if (hit_edge)   rdata = DW'(edge_q);
      for (int i = 0; i < NSEV; i++) begin
         if (sev_hit[i]) rdata = sev_rword[i];
      end
   end

   assign prdata = rd_acc ? rdata : '0;

   // R12
   rev_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && hit_ctrl) |-> (prdata[CB_REV_LO+1:CB_REV_LO] == REV_VAL));

   // R12
   unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && !in_grp) |-> (prdata == '0));

   // R11
   line_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_summary || (|sev_line)) |-> (cause_q != '0));

   // R4
   mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc && hit_mclr && !(ctrl_q.ack_msk && (|irq_ack)))
      |=> ((mask_q & ~$past(wdata)) == '0));

endmodule

// File: tb/test_irq_group_bank.sv
`timescale 1ns/1ps
module test_irq_group_bank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic [31:0] src_in = '0;
   logic [31:0] irq_ack = '0;
   logic        irq_summary, sev_error, sev_abort, sev_fatal, sev_log;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   irq_group_bank #(.NSRC(32), .ADDR_W(12), .SYNC_STAGES(2)) i_irq_group_bank (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .src_in(src_in),
      .irq_ack(irq_ack), .irq_summary(irq_summary), .sev_error(sev_error),
      .sev_abort(sev_abort), .sev_fatal(sev_fatal), .sev_log(sev_log)
   );

   // ---------------- reference model ----------------
   logic [31:0] m_s1, m_s2, m_status, m_cause, m_mask, m_edge, m_ctrl;
   logic [31:0] m_sev [4];
   logic [31:0] t_em, t_hw, t_c, t_m;
   logic        t_wr, t_rd;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 <= '0; m_s2 <= '0; m_status <= '0; m_cause <= '0;
         m_mask <= '1; m_edge <= '0; m_ctrl <= '0;
         for (int k = 0; k < 4; k++) m_sev[k] <= '1;
      end else begin
         t_wr = psel && penable && pwrite;
         t_rd = psel && penable && !pwrite;
         t_em = m_ctrl[6] ? {32{m_ctrl[3]}} : m_edge;
         t_hw = m_s2 & ~(t_em & m_status);
         t_c  = m_cause;
         if (t_rd && paddr == 12'h000 && m_ctrl[0]) t_c = '0;
         if (t_wr && paddr == 12'h000) t_c = t_c & pwdata;
         if (m_ctrl[2]) t_c = t_c & ~irq_ack;
         if (t_wr && paddr == 12'h008) t_c = t_c | pwdata;
         t_c = t_c | t_hw;
         t_m = m_mask;
         if (t_wr && paddr == 12'h010) t_m = pwdata;
         if (t_wr && paddr == 12'h018) t_m = t_m & pwdata;
         if (m_ctrl[1]) t_m = t_m | irq_ack;
         m_s1 <= src_in; m_s2 <= m_s1; m_status <= m_s2;
         m_cause <= t_c; m_mask <= t_m;
         if (t_wr) begin
            case (paddr)
               12'h028: m_ctrl   <= pwdata & 32'h0000_004F;
               12'h02C: m_sev[0] <= pwdata;
               12'h030: m_sev[1] <= pwdata;
               12'h034: m_sev[2] <= pwdata;
               12'h038: m_sev[3] <= pwdata;
               12'h03C: m_edge   <= pwdata;
               default: ;
            endcase
         end
      end
   end

   function automatic logic [31:0] exp_read(input logic [11:0] a);
      case (a)
         12'h000: return m_cause;
         12'h010: return m_mask;
         12'h020: return m_status;
         12'h028: return m_ctrl | 32'h1000_0000;
         12'h02C: return m_sev[0];
         12'h030: return m_sev[1];
         12'h034: return m_sev[2];
         12'h038: return m_sev[3];
         12'h03C: return m_edge;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [31:0] exp_lines();
      return {27'b0, |(m_cause & ~m_mask), |(m_cause & ~m_sev[0]),
              |(m_cause & ~m_sev[1]), |(m_cause & ~m_sev[2]), |(m_cause & ~m_sev[3])};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // R11: output lines compared every cycle
   always @(negedge clk) begin
      if (rst_n && !done)
         check("R11", {27'b0, irq_summary, sev_error, sev_abort, sev_fatal, sev_log}, exp_lines());
   end

   // ---------------- bus tasks ----------------
   task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
      @(negedge clk); penable = 1;
      @(negedge clk); psel = 0; penable = 0; pwrite = 0;
   endtask

   task automatic apb_read(input logic [11:0] a, input string tag);
      @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
      @(negedge clk); penable = 1;
      #1 check(tag, prdata, exp_read(a));
      @(negedge clk); psel = 0; penable = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_ack(input logic [31:0] v);
      @(negedge clk); irq_ack = v;
      @(negedge clk); irq_ack = '0;
   endtask

   localparam logic [11:0] OFFS [14] = '{12'h000, 12'h008, 12'h010, 12'h018, 12'h020,
      12'h028, 12'h02C, 12'h030, 12'h034, 12'h038, 12'h03C, 12'h004, 12'h100, 12'h040};

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      void'($urandom(32'd7341));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values, R12 write-only and unmapped reads
      foreach (OFFS[k]) apb_read(OFFS[k], "R1");
      check("R1", {27'b0, irq_summary, sev_error, sev_abort, sev_fatal, sev_log}, 32'h0);
      check("R1", prdata, 32'h0);

      // R3 cause-set
      apb_write(12'h008, 32'h0000_0005);
      apb_read(12'h000, "R3");
      check("R3", m_cause, 32'h5);
      apb_read(12'h008, "R3");
      // R2 write-zero clear
      apb_write(12'h000, 32'hFFFF_FFFE);
      apb_read(12'h000, "R2");
      apb_write(12'h000, 32'hFFFF_FFFF);
      apb_read(12'h000, "R2");
      check("R2", m_cause, 32'h4);
      // R4 mask and mask-clear
      apb_write(12'h018, 32'hFFFF_FFFB);
      apb_read(12'h010, "R4");
      apb_write(12'h010, 32'hFFFF_FF00);
      apb_read(12'h010, "R4");
      apb_write(12'h018, 32'hFFFF_FF7F);
      apb_read(12'h010, "R4");
      // R11 severity lines
      apb_write(12'h02C, 32'hFFFF_FFFB);
      idle(1);
      check("R11", {30'b0, sev_error, sev_fatal}, 32'h2);
      apb_write(12'h034, 32'h0);
      apb_read(12'h034, "R11");
      apb_write(12'h000, 32'h0);
      // R5 level capture and three-edge latency
      @(negedge clk); src_in = 32'h100;
      @(posedge clk); @(posedge clk);
      #1 check("R5", i_irq_group_bank.prdata, 32'h0);
      check("R5", {31'b0, irq_summary}, {31'b0, |(m_cause & ~m_mask)});
      idle(3);
      apb_read(12'h000, "R5");
      apb_read(12'h020, "R5");
      // R10 hardware set beats software clear
      apb_write(12'h000, 32'h0);
      apb_read(12'h000, "R10");
      check("R10", m_cause & 32'h100, 32'h100);
      // R6 edge capture
      apb_write(12'h03C, 32'h200);
      @(negedge clk); src_in = 32'h300;
      idle(4);
      apb_write(12'h000, 32'hFFFF_FDFF);
      apb_read(12'h000, "R6");
      apb_read(12'h020, "R6");
      @(negedge clk); src_in = 32'h100;
      idle(4);
      @(negedge clk); src_in = 32'h300;
      idle(4);
      apb_read(12'h000, "R6");
      // R7 group override
      apb_write(12'h028, 32'h48);
      apb_write(12'h000, 32'h0);
      apb_read(12'h000, "R7");
      apb_write(12'h028, 32'h40);
      apb_read(12'h000, "R7");
      // R8 clear on read
      @(negedge clk); src_in = '0;
      idle(4);
      apb_write(12'h000, 32'h0);
      apb_write(12'h028, 32'h01);
      apb_write(12'h008, 32'h0000_00A0);
      apb_read(12'h000, "R8");
      apb_read(12'h000, "R8");
      // R9 acknowledge
      apb_write(12'h028, 32'h06);
      apb_write(12'h008, 32'h30);
      apb_write(12'h018, 32'h0);
      pulse_ack(32'h10);
      apb_read(12'h000, "R9");
      apb_read(12'h010, "R9");
      // R12 unmapped offsets and control readback
      apb_write(12'h004, 32'hFFFF_FFFF);
      apb_write(12'h100, 32'hFFFF_FFFF);
      apb_write(12'h048, 32'hFFFF_FFFF);
      apb_read(12'h000, "R12");
      apb_read(12'h010, "R12");
      apb_read(12'h100, "R12");
      apb_write(12'h028, 32'hFFFF_FFFF);
      apb_read(12'h028, "R12");
      apb_write(12'h028, 32'h0);

      // constrained random mix
      for (int it = 0; it < 3000; it++) begin
         int op;
         op = int'($urandom % 8);
         case (op)
            0, 1, 2: apb_write(OFFS[$urandom % 14], $urandom);
            3, 4:    apb_read(OFFS[$urandom % 14], "R2");
            5:       begin @(negedge clk); src_in = $urandom & $urandom; end
            6:       pulse_ack($urandom & $urandom);
            default: idle(1);
         endcase
      end

      idle(2);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule